// File: doc/BRIEF.md
# Euclidean Branch Metric Generator for Sequence Estimation

This block produces the incremental branch metrics that a Viterbi-style maximum-likelihood sequence estimator feeds into its add-compare-select stage. For a chosen channel memory C (2 to 6), it enumerates every one of the 2^C transition hypotheses k. For each one it builds a complex estimate of the received sample by weighting the channel taps with antipodal symbols taken from the bits of k. It then measures how far the actual received I/Q sample lies from that estimate.

Each component error is taken as a magnitude and clipped to 255. The two clipped values are squared and added, and the 17-bit total is halved to a 16-bit metric. A single start pulse captures the received sample, the packed tap vector and C. The block then streams one metric per clock, in ascending k, with a valid flag, the hypothesis index and an end marker on the final metric.

Top module: `mlse_bm_unit`

## Requirements
- R1: After reset, `busy`, `bm_valid` and `bm_done` are all low.
- R2: A `start` sampled high while `busy` is low is accepted. `busy` is high at the next edge, and metrics follow with `bm_valid` high on consecutive clocks. The first metric comes one edge after `busy` rises, and `bm_index` runs 0, 1, 2, ... up to 2^C−1.
- R3: `bm_done` is high only together with the metric for k = 2^C−1. At that same edge `busy` returns low, and `bm_valid` is low on the following edge unless a new run has started.
- R4: The `clen` value is limited when it is captured. Values below 2 act as 2, and values above 6 act as 6, so 2^C metrics are issued for the limited C.
- R5: Bit i of k selects the symbol for tap i: 0 means +1 and 1 means −1. The estimate is the sum of symbol times tap over taps 0 to C−1 only. Taps at positions C and above have no effect.
- R6: Tap i occupies `taps[16i+15:16i]`. The in-phase part is in bits `[16i+15:16i+8]` and the quadrature part in bits `[16i+7:16i]`, both 8-bit two's complement. `zi` and `zq` are 10-bit two's complement.
- R7: The metric equals (min(|zi−EI(k)|,255)² + min(|zq−EQ(k)|,255)²) shifted right by one bit, as an unsigned 16-bit value.
- R8: Each component magnitude saturates at 255. A metric therefore never exceeds 0xFE01, and it reaches that value when both components are clipped.
- R9: `zi`, `zq`, `taps` and `clen` are captured at the accepted start. Changing them during a run does not alter that run's metrics.
- R10: A `start` pulse while `busy` is high is ignored. The run keeps its count and ends normally, and no extra run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a run of 2^C metrics |
| clen | input | 3 | Channel memory C, limited to 2..6 |
| taps | input | 96 | Six packed complex taps, I in upper byte, Q in lower byte |
| zi | input | 10 | Received in-phase sample, two's complement |
| zq | input | 10 | Received quadrature sample, two's complement |
| busy | output | 1 | A run is in progress |
| bm_valid | output | 1 | `bm_metric` and `bm_index` are valid |
| bm_index | output | 6 | Hypothesis k of the current metric |
| bm_metric | output | 16 | Truncated Euclidean branch metric |
| bm_done | output | 1 | Marks the last metric of a run |

## Verification
A corrupted hypothesis counter shows at once in the index stream: it breaks the step-by-one sequence or puts the end marker on the wrong index. A wrong symbol mapping or tap slice first shows in the metric of the lowest k whose affected bit is 1, so it appears within one to 2^(C−1) cycles of the first metric. A fault in the clip, square or shift stage changes every metric of a run whose error magnitude crosses 255, and the deliberately clipped scenarios expose it on their first metric. A capture fault appears as soon as the bench disturbs the inputs right after the start.

// File: rtl/mlse_bm_pkg.sv
package mlse_bm_pkg;
  localparam int MAX_TAPS  = 6;   // deepest supported channel memory
  localparam int MIN_TAPS  = 2;   // shallowest supported channel memory
  localparam int TAP_HW    = 8;   // width of one tap half (I or Q)
  localparam int SMP_W     = 10;  // received sample width
  localparam int CLIP_W    = 8;   // width after magnitude clipping
endpackage

// File: rtl/mlse_bm_ctrl.sv
// Run sequencer: accepts a start, walks k from 0 to 2^C-1.
module mlse_bm_ctrl #(
  parameter int MAX_C = 6,
  parameter int MIN_C = 2,
  parameter int CW    = 3,
  parameter int KW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] clen_in,
  output logic          accept,
  output logic          run,
  output logic [KW-1:0] k,
  output logic [CW-1:0] clen_eff,
  output logic          last
);

  logic          run_q, run_d;
  logic [KW-1:0] k_q, k_d;
  logic [CW-1:0] clen_q, clen_d;
  logic [CW-1:0] clen_lim;
  logic [KW:0]   k_end;

  always_comb begin
    if (clen_in < CW'(MIN_C))      clen_lim = CW'(MIN_C);
    else if (clen_in > CW'(MAX_C)) clen_lim = CW'(MAX_C);
    else                           clen_lim = clen_in;
  end

  always_comb begin
    accept = start && !run_q;
    k_end  = ((KW+1)'(1) << clen_q) - (KW+1)'(1);
    last   = ({1'b0, k_q} == k_end);
  end

  always_comb begin
    run_d  = run_q;
    k_d    = k_q;
    clen_d = clen_q;
    if (accept) begin
      run_d  = 1'b1;
      k_d    = '0;
      clen_d = clen_lim;
    end else if (run_q) begin
      k_d = k_q + KW'(1);
      if (last) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      k_q    <= '0;
      clen_q <= CW'(MIN_C);
    end else begin
      run_q  <= run_d;
      k_q    <= k_d;
      clen_q <= clen_d;
    end
  end

  assign run      = run_q;
  assign k        = k_q;
  assign clen_eff = clen_q;

endmodule

// File: rtl/mlse_bm_estimate.sv
// Builds EI(k), EQ(k) = sum over active taps of (+/-1) * h(i).
module mlse_bm_estimate #(
  parameter int MAX_C = 6,
  parameter int HW    = 8,
  parameter int CW    = 3,
  parameter int KW    = 6,
  parameter int EW    = 12
) (
  input  logic [MAX_C*2*HW-1:0] taps,
  input  logic [KW-1:0]         k,
  input  logic [CW-1:0]         clen,
  output logic signed [EW-1:0]  est_i,
  output logic signed [EW-1:0]  est_q
);

  logic signed [EW-1:0] term_i [MAX_C];
  logic signed [EW-1:0] term_q [MAX_C];

  for (genvar g = 0; g < MAX_C; g++) begin : g_tap
    logic signed [HW-1:0] h_re, h_im;
    logic signed [EW-1:0] x_re, x_im;
    logic                 active;
    assign h_re   = taps[g*2*HW+2*HW-1 -: HW];
    assign h_im   = taps[g*2*HW+HW-1 -: HW];
    assign x_re   = EW'(h_re);
    assign x_im   = EW'(h_im);
    assign active = (clen > CW'(g));
    always_comb begin
      if (!active) begin
        term_i[g] = '0;
        term_q[g] = '0;
      end else if (k[g]) begin
        term_i[g] = -x_re;
        term_q[g] = -x_im;
      end else begin
        term_i[g] = x_re;
        term_q[g] = x_im;
      end
    end
  end

  always_comb begin
    est_i = '0;
    est_q = '0;
    for (int i = 0; i < MAX_C; i++) begin
      est_i = est_i + term_i[i];
      est_q = est_q + term_q[i];
    end
  end

endmodule

// File: rtl/mlse_bm_comp.sv
// One component: |z - e|, clipped, squared.
module mlse_bm_comp #(
  parameter int SW     = 10,
  parameter int EW     = 12,
  parameter int CLIP_W = 8
) (
  input  logic signed [SW-1:0]   z,
  input  logic signed [EW-1:0]   e,
  output logic [2*CLIP_W-1:0]    sq
);

  localparam int DW       = ((EW > SW) ? EW : SW) + 1;
  localparam int CLIP_MAX = (1 << CLIP_W) - 1;

  logic signed [DW-1:0] diff;
  logic [DW-1:0]        mag;
  logic [CLIP_W-1:0]    clip;

  always_comb begin
    diff = DW'(z) - DW'(e);
    mag  = diff[DW-1] ? DW'(-diff) : DW'(diff);
    clip = (mag > DW'(CLIP_MAX)) ? CLIP_W'(CLIP_MAX) : CLIP_W'(mag);
    sq   = clip * clip;
  end

endmodule

// File: rtl/mlse_bm_unit.sv
module mlse_bm_unit #(
  parameter int MAX_C  = mlse_bm_pkg::MAX_TAPS,
  parameter int MIN_C  = mlse_bm_pkg::MIN_TAPS,
  parameter int HW     = mlse_bm_pkg::TAP_HW,
  parameter int SW     = mlse_bm_pkg::SMP_W,
  parameter int CLIP_W = mlse_bm_pkg::CLIP_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [$clog2(MAX_C+1)-1:0] clen,
  input  logic [MAX_C*2*HW-1:0]     taps,
  input  logic signed [SW-1:0]      zi,
  input  logic signed [SW-1:0]      zq,
  output logic                      busy,
  output logic                      bm_valid,
  output logic [MAX_C-1:0]          bm_index,
  output logic [2*CLIP_W-1:0]       bm_metric,
  output logic                      bm_done
);

  localparam int CW    = $clog2(MAX_C+1);
  localparam int KW    = MAX_C;
  localparam int EW    = HW + $clog2(MAX_C) + 1;
  localparam int SQ_W  = 2*CLIP_W;
  localparam int SUM_W = SQ_W + 1;
  localparam int BM_W  = SUM_W - 1;
  localparam int TW    = MAX_C*2*HW;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic          accept, run, last;
  logic [KW-1:0] k;
  logic [CW-1:0] clen_eff;

  mlse_bm_ctrl #(.MAX_C(MAX_C), .MIN_C(MIN_C), .CW(CW), .KW(KW)) u_ctrl (
    .clk(clk), .rst_n(rst_sync), .start(start), .clen_in(clen),
    .accept(accept), .run(run), .k(k), .clen_eff(clen_eff), .last(last)
  );

  // operand capture on accepted start
  logic signed [SW-1:0] zi_q, zq_q, zi_d, zq_d;
  logic [TW-1:0]        taps_q, taps_d;

  always_comb begin
    zi_d   = accept ? zi   : zi_q;
    zq_d   = accept ? zq   : zq_q;
    taps_d = accept ? taps : taps_q;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      zi_q   <= '0;
      zq_q   <= '0;
      taps_q <= '0;
    end else begin
      zi_q   <= zi_d;
      zq_q   <= zq_d;
      taps_q <= taps_d;
    end
  end

  logic signed [EW-1:0] est_i, est_q;

  mlse_bm_estimate #(.MAX_C(MAX_C), .HW(HW), .CW(CW), .KW(KW), .EW(EW)) u_est (
    .taps(taps_q), .k(k), .clen(clen_eff), .est_i(est_i), .est_q(est_q)
  );

  logic [SQ_W-1:0] sq_i, sq_q;

  mlse_bm_comp #(.SW(SW), .EW(EW), .CLIP_W(CLIP_W)) u_comp_i (
    .z(zi_q), .e(est_i), .sq(sq_i)
  );
  mlse_bm_comp #(.SW(SW), .EW(EW), .CLIP_W(CLIP_W)) u_comp_q (
    .z(zq_q), .e(est_q), .sq(sq_q)
  );

  logic [SUM_W-1:0] sum;
  logic [BM_W-1:0]  metric_c;

  always_comb begin
    sum      = SUM_W'(sq_i) + SUM_W'(sq_q);
    metric_c = BM_W'(sum >> 1);
  end

  // output stage
  logic            valid_q, valid_d, done_q, done_d;
  logic [KW-1:0]   idx_q, idx_d;
  logic [BM_W-1:0] metric_q, metric_d;

  always_comb begin
    valid_d  = run;
    done_d   = run && last;
    idx_d    = run ? k : idx_q;
    metric_d = run ? metric_c : metric_q;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      valid_q  <= 1'b0;
      done_q   <= 1'b0;
      idx_q    <= '0;
      metric_q <= '0;
    end else begin
      valid_q  <= valid_d;
      done_q   <= done_d;
      idx_q    <= idx_d;
      metric_q <= metric_d;
    end
  end

  assign busy      = run;
  assign bm_valid  = valid_q;
  assign bm_done   = done_q;
  assign bm_index  = idx_q;
  assign bm_metric = metric_q;

endmodule

// File: rtl/mlse_bm_unit_chk.sv
module mlse_bm_unit_chk #(
  parameter int KW     = 6,
  parameter int CLIP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              bm_valid,
  input logic [KW-1:0]     bm_index,
  input logic [2*CLIP_W-1:0] bm_metric,
  input logic              bm_done
);

  localparam int CMAX  = (1 << CLIP_W) - 1;
  localparam int MMAX  = (2 * CMAX * CMAX) >> 1;

  AST_VALID_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bm_valid |-> $past(busy)); // R2
  AST_FIRST_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bm_valid) |-> (bm_index == '0)); // R2
  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_valid && !bm_done) |=> (bm_valid && bm_index == $past(bm_index) + KW'(1))); // R2
  AST_DONE_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    bm_done |-> (bm_valid && !busy)); // R3
  AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    bm_done |=> !bm_valid); // R3
  AST_DONE_INDEX_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    bm_done |-> (((bm_index & (bm_index + KW'(1))) == '0) && bm_index >= KW'(3))); // R4
  AST_METRIC_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    bm_valid |-> (bm_metric <= (2*CLIP_W)'(MMAX))); // R8

endmodule

bind mlse_bm_unit mlse_bm_unit_chk #(.KW(MAX_C), .CLIP_W(CLIP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .bm_valid(bm_valid),
  .bm_index(bm_index), .bm_metric(bm_metric), .bm_done(bm_done)
);

// File: tb/mlse_bm_unit_test.sv
module mlse_bm_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  clen;
  logic [95:0] taps;
  logic signed [9:0] zi, zq;
  logic        busy, bm_valid, bm_done;
  logic [5:0]  bm_index;
  logic [15:0] bm_metric;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  mlse_bm_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .clen(clen), .taps(taps),
    .zi(zi), .zq(zq), .busy(busy), .bm_valid(bm_valid),
    .bm_index(bm_index), .bm_metric(bm_metric), .bm_done(bm_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] tap(input int re, input int im);
    logic [7:0] a, b;
    a = 8'(re);
    b = 8'(im);
    return {a, b};
  endfunction

  function automatic int model(input int c, input int k, input logic [95:0] t,
                               input int z_i, input int z_q);
    int ei, eq, xi, xq, hr, hq;
    ei = 0;
    eq = 0;
    for (int i = 0; i < c; i++) begin
      hr = int'($signed(t[16*i+15 -: 8]));
      hq = int'($signed(t[16*i+7 -: 8]));
      if ((k >> i) & 1) begin
        ei -= hr;
        eq -= hq;
      end else begin
        ei += hr;
        eq += hq;
      end
    end
    xi = z_i - ei; if (xi < 0) xi = -xi; if (xi > 255) xi = 255;
    xq = z_q - eq; if (xq < 0) xq = -xq; if (xq > 255) xq = 255;
    return (xi*xi + xq*xq) >> 1;
  endfunction

  // runs one full sequence and checks every metric (R2, R3, R7, R9; poke: R10)
  task automatic run_case(input int c_in, input logic [95:0] t, input int z_i,
                          input int z_q, input bit poke, input string req);
    int c, n, e;
    c = (c_in < 2) ? 2 : ((c_in > 6) ? 6 : c_in);
    n = 1 << c;
    @(negedge clk);
    start = 1'b1; clen = 3'(c_in); taps = t; zi = 10'(z_i); zq = 10'(z_q);
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, {req, " R2 busy after start"}, int'(busy), 1);
    check(bm_valid === 1'b0, {req, " R2 no metric yet"}, int'(bm_valid), 0);
    // R9: disturb operands once the run is captured
    zi = ~zi; zq = ~zq; taps = ~taps; clen = 3'(c_in + 3);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      start = (poke && k == 1);
      e = model(c, k, t, z_i, z_q);
      check(bm_valid === 1'b1, {req, " R2 valid"}, int'(bm_valid), 1);
      check(bm_index === 6'(k), {req, " R2 index"}, int'(bm_index), k);
      check(bm_metric === 16'(e), {req, " R7 metric"}, int'(bm_metric), e);
      check(bm_done === (k == n-1), {req, " R3 done position"}, int'(bm_done), int'(k == n-1));
    end
    start = 1'b0;
    check(busy === 1'b0, {req, " R3 busy ends with last"}, int'(busy), 0);
    @(negedge clk);
    check(bm_valid === 1'b0, {req, " R3/R10 no extra metric"}, int'(bm_valid), 0);
    check(busy === 1'b0, {req, " R10 no restart"}, int'(busy), 0);
  endtask

  task automatic t_reset();
    check(busy === 1'b0, "R1 busy", int'(busy), 0);
    check(bm_valid === 1'b0, "R1 valid", int'(bm_valid), 0);
    check(bm_done === 1'b0, "R1 done", int'(bm_done), 0);
  endtask

  task automatic t_basic();   // R6 packing, R5 mapping
    run_case(2, {64'h0, tap(-20, 7), tap(35, -12)}, 40, -25, 1'b0, "basic_c2 R5 R6");
  endtask

  task automatic t_full();    // deepest memory, mixed signs
    run_case(6, {tap(5, -3), tap(-9, 11), tap(14, 2), tap(-30, -17), tap(22, 40), tap(61, -58)},
             -130, 95, 1'b0, "full_c6 R7");
  endtask

  task automatic t_clamp_low();
    run_case(0, {64'h0, tap(10, 10), tap(-10, 20)}, 3, 4, 1'b0, "clamp_low R4");
  endtask

  task automatic t_clamp_high();
    run_case(7, {tap(1, 2), tap(3, 4), tap(-5, -6), tap(7, 8), tap(-9, 10), tap(11, -12)},
             100, -100, 1'b0, "clamp_high R4");
  endtask

  task automatic t_saturate(); // both components clipped at k=0: 0xFE01 (R8)
    run_case(2, {64'h0, tap(-127, 127), tap(-128, 127)}, 511, -512, 1'b0, "saturate R8");
  endtask

  task automatic t_unused();   // taps beyond C ignored (R5)
    run_case(3, {tap(127, 127), tap(127, -128), tap(-128, 127), tap(40, -6), tap(-19, 33), tap(8, 50)},
             -60, 12, 1'b0, "unused_taps R5");
  endtask

  task automatic t_restart();  // start during run ignored (R10)
    run_case(3, {64'h0, tap(0, 0), tap(16, -16), tap(-4, 9)}, 200, -300, 1'b1, "restart R10");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; clen = 3'd2; taps = '0; zi = '0; zq = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_full();
    t_clamp_low();
    t_clamp_high();
    t_saturate();
    t_unused();
    t_restart();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule